// File: doc/BRIEF.md
# CAN Operating Mode Controller

This block holds the operating mode of a CAN protocol engine and is the only place that decides when that mode may change. Software presents a 3-bit mode request. The block keeps the request as a target. It moves the reported mode to that target only after the bus has been idle long enough. Its outputs tell the rest of the controller what it may do in the current mode:
- whether it may receive;
- whether it may start a transmission;
- whether the error counters run, stay frozen or are held clear;
- whether configuration registers may be written;
- which pins belong to the bus;
- whether the receive path is fed from the internal transmit signal.

Bus idleness is measured on the sampled receive line at each bit-sample strobe. A recessive sample (logic 1) advances a saturating idle counter, and a dominant sample (logic 0) clears it. The counter also restarts whenever a new mode is entered. Because of that restart, a transmission requested right after entry waits for a fresh idle window. If Disable is requested inside that window, the pending transmission is aborted.

While the block is in Disable mode it watches the receive line for wake-up activity. An optional low-pass filter, active only during sleep, can require several dominant samples in a row before a wake event is reported. All control and status pins are plain levels or single-cycle pulses. No streaming data passes through this block, so it has no valid/ready interface and no back-pressure.

Top module: `can_mode_ctrl`

## Requirements
- R1: After reset the reported mode is 3'b100 (Initialization), configuration writes are enabled, and tx_grant, tx_abort and wake_evt are low.
- R2: Mode codes are 000 Normal, 001 Disable, 010 Loopback, 011 Listen Only, 100 Initialization and 111 Listen All Messages. mode_stat reports the entered mode in the same code. Request codes 101 and 110 are ignored and leave the pending target unchanged.
- R3: A pending change takes effect on the clock after the idle counter has reached 11. The counter advances on each strobe with rx_in=1 and is cleared by any strobe with rx_in=0. Until the change, mode_stat keeps the old code.
- R4: A new valid request made while a change is pending replaces the target. The idle counter is not restarted by the new request.
- R5: A change into Initialization is held off while tx_busy is high.
- R6: In Initialization mode, receive and transmit are off, err_cnt_clr is high and cfg_wr_en is high. cfg_wr_en is low in every other mode.
- R7: In Disable mode, all enables, error-counter controls and pin ownership outputs are low, so the counters hold their values and the pins are released.
- R8: In Listen Only mode, only rx_en and rx_pin_own are high. There are no acknowledges or error flags, the counters are frozen and the transmit pin is released.
- R9: In Loopback mode, loop_sel is high, rx_core equals tx_bit, both pin ownership outputs are low, and reception and error counting stay on.
- R10: In Listen All Messages mode, accept_all, rx_en and rx_pin_own are high. Acknowledges and error flags are off and the counters are frozen.
- R11: tx_grant is high only while tx_req is high, the mode is Normal or Loopback, no change is pending, and the idle counter has reached 11 since the mode was entered.
- R12: tx_abort and tx_req_clr pulse for one cycle when, in Normal or Loopback before the post-entry idle window completes, tx_req is high and the pending target is Disable.
- R13: In Disable mode, each strobe with rx_in=0 pulses wake_evt one cycle later. When wake_filt_en and sleep_mode are both high, the pulse comes only on the third dominant strobe in a row, and only once per run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_req | input | 3 | Requested mode code |
| bit_tick | input | 1 | Bit-sample strobe |
| rx_in | input | 1 | Sampled bus receive line |
| tx_bit | input | 1 | Internal transmit bit stream |
| tx_busy | input | 1 | A frame is being transmitted |
| tx_req | input | 1 | A transmit buffer requests to send |
| wake_filt_en | input | 1 | Wake low-pass filter enable |
| sleep_mode | input | 1 | Device is asleep |
| mode_stat | output | 3 | Active mode code |
| tx_grant | output | 1 | Transmission may start |
| tx_abort | output | 1 | Pending transmission aborted (pulse) |
| tx_req_clr | output | 1 | Clear the transmit request (pulse) |
| rx_en | output | 1 | Receive path enabled |
| err_cnt_clr | output | 1 | Hold error counters at zero |
| err_cnt_run | output | 1 | Error counters may count |
| ack_err_en | output | 1 | Node may drive acknowledges and error flags |
| accept_all | output | 1 | Accept all frames, ignore errors |
| cfg_wr_en | output | 1 | Configuration registers writable |
| tx_pin_own | output | 1 | Transmit pin belongs to the bus |
| rx_pin_own | output | 1 | Receive pin belongs to the bus |
| loop_sel | output | 1 | Receive path fed from tx_bit |
| rx_core | output | 1 | Receive bit seen by the protocol engine |
| wake_evt | output | 1 | Wake-up activity detected (pulse) |

## Verification
The bench targets four edges of the block.

The first is the eleventh recessive strobe. A design whose counter is off by one switches a strobe early or late, and the bench sees mode_stat change on the wrong cycle.

The second is a request replaced mid-wait. A design that restarts the counter on the new request holds the old status several strobes too long. A design that keeps the old target reports the wrong code.

The third covers the Initialization block on tx_busy and the Disable-during-post-entry-window abort. Getting these wrong shows up either as an early switch into Initialization or as a missing or repeated abort pulse.

The fourth is the sleep wake filter. A design that counts dominant strobes across recessive gaps, or that fires more than once per run, gives a wake count that does not match.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

  typedef enum logic [2:0] {
    MD_NORM = 3'b000,
    MD_DIS  = 3'b001,
    MD_LOOP = 3'b010,
    MD_LSTN = 3'b011,
    MD_INIT = 3'b100,
    MD_LALL = 3'b111
  } can_mode_e;

  typedef struct packed {
    logic rx_en;
    logic err_clr;
    logic err_run;
    logic ack_err_en;
    logic accept_all;
    logic cfg_wr_en;
    logic tx_pin_own;
    logic rx_pin_own;
    logic loop_sel;
  } path_ctl_t;

  function automatic logic mode_code_ok(input logic [2:0] code);
    return (code != 3'b101) && (code != 3'b110);
  endfunction

  function automatic logic mode_can_tx(input can_mode_e m);
    return (m == MD_NORM) || (m == MD_LOOP);
  endfunction

endpackage

// File: rtl/can_idle_mon.sv
module can_idle_mon #(
  parameter int IDLE_BITS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic rx_in,
  input  logic restart,
  output logic idle_ok
);
  localparam int CW = $clog2(IDLE_BITS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(IDLE_BITS);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      run_q <= '0;
    end else if (bit_tick) begin
      if (!rx_in)              run_q <= '0;
      else if (run_q != LIMIT) run_q <= run_q + 1'b1;
    end
  end

  assign idle_ok = (run_q == LIMIT);
endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
  import can_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_req,
  input  logic       tx_busy,
  input  logic       tx_req,
  input  logic       idle_ok,
  output can_mode_e  mode_q,
  output logic       pending,
  output logic       switch_now,
  output logic       abort_pulse
);
  can_mode_e tgt_q;
  logic      abort_lvl, abort_lvl_q;

  assign pending    = (tgt_q != mode_q);
  assign switch_now = pending && idle_ok && !((tgt_q == MD_INIT) && tx_busy);
  assign abort_lvl  = mode_can_tx(mode_q) && !idle_ok && tx_req && (tgt_q == MD_DIS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q      <= MD_INIT;
      tgt_q       <= MD_INIT;
      abort_lvl_q <= 1'b0;
      abort_pulse <= 1'b0;
    end else begin
      if (switch_now)             mode_q <= tgt_q;
      if (mode_code_ok(mode_req)) tgt_q  <= can_mode_e'(mode_req);
      abort_lvl_q <= abort_lvl;
      abort_pulse <= abort_lvl && !abort_lvl_q;
    end
  end
endmodule

// File: rtl/can_wake_det.sv
module can_wake_det #(
  parameter int FILT_BITS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_disable,
  input  logic bit_tick,
  input  logic rx_in,
  input  logic filt_on,
  output logic wake_evt
);
  localparam int FW = $clog2(FILT_BITS + 1);
  localparam logic [FW-1:0] FLIM = FW'(FILT_BITS);

  logic [FW-1:0] dom_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !in_disable) begin
      dom_q    <= '0;
      wake_evt <= 1'b0;
    end else if (bit_tick && !rx_in) begin
      if (dom_q != FLIM) dom_q <= dom_q + 1'b1;
      wake_evt <= filt_on ? (dom_q == FLIM - 1'b1) : 1'b1;
    end else begin
      if (bit_tick) dom_q <= '0;
      wake_evt <= 1'b0;
    end
  end
endmodule

// File: rtl/can_path_ctrl.sv
module can_path_ctrl
  import can_mode_pkg::*;
(
  input  can_mode_e mode,
  input  logic      tx_req,
  input  logic      idle_ok,
  input  logic      pending,
  input  logic      rx_in,
  input  logic      tx_bit,
  output path_ctl_t ctl,
  output logic      tx_grant,
  output logic      rx_core
);
  always_comb begin
    ctl = '0;
    unique case (mode)
      MD_INIT: begin
        ctl.err_clr    = 1'b1;
        ctl.cfg_wr_en  = 1'b1;
        ctl.tx_pin_own = 1'b1;
        ctl.rx_pin_own = 1'b1;
      end
      MD_NORM: begin
        ctl.rx_en      = 1'b1;
        ctl.err_run    = 1'b1;
        ctl.ack_err_en = 1'b1;
        ctl.tx_pin_own = 1'b1;
        ctl.rx_pin_own = 1'b1;
      end
      MD_LOOP: begin
        ctl.rx_en      = 1'b1;
        ctl.err_run    = 1'b1;
        ctl.ack_err_en = 1'b1;
        ctl.loop_sel   = 1'b1;
      end
      MD_LSTN: begin
        ctl.rx_en      = 1'b1;
        ctl.rx_pin_own = 1'b1;
      end
      MD_LALL: begin
        ctl.rx_en      = 1'b1;
        ctl.accept_all = 1'b1;
        ctl.rx_pin_own = 1'b1;
      end
      default: ctl = '0;
    endcase
  end

  assign tx_grant = tx_req && mode_can_tx(mode) && idle_ok && !pending;
  assign rx_core  = ctl.loop_sel ? tx_bit : (ctl.rx_pin_own ? rx_in : 1'b1);
endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
  import can_mode_pkg::*;
#(
  parameter int IDLE_BITS      = 11,
  parameter int WAKE_FILT_BITS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_req,
  input  logic       bit_tick,
  input  logic       rx_in,
  input  logic       tx_bit,
  input  logic       tx_busy,
  input  logic       tx_req,
  input  logic       wake_filt_en,
  input  logic       sleep_mode,
  output logic [2:0] mode_stat,
  output logic       tx_grant,
  output logic       tx_abort,
  output logic       tx_req_clr,
  output logic       rx_en,
  output logic       err_cnt_clr,
  output logic       err_cnt_run,
  output logic       ack_err_en,
  output logic       accept_all,
  output logic       cfg_wr_en,
  output logic       tx_pin_own,
  output logic       rx_pin_own,
  output logic       loop_sel,
  output logic       rx_core,
  output logic       wake_evt
);
  can_mode_e mode;
  logic      idle_ok, pending, switch_now, abort_pulse;
  path_ctl_t ctl;

  can_idle_mon #(.IDLE_BITS(IDLE_BITS)) u_idle (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_in(rx_in),
    .restart(switch_now), .idle_ok(idle_ok)
  );

  can_mode_seq u_seq (
    .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .tx_busy(tx_busy),
    .tx_req(tx_req), .idle_ok(idle_ok), .mode_q(mode), .pending(pending),
    .switch_now(switch_now), .abort_pulse(abort_pulse)
  );

  can_wake_det #(.FILT_BITS(WAKE_FILT_BITS)) u_wake (
    .clk(clk), .rst_n(rst_n), .in_disable(mode == MD_DIS), .bit_tick(bit_tick),
    .rx_in(rx_in), .filt_on(wake_filt_en && sleep_mode), .wake_evt(wake_evt)
  );

  can_path_ctrl u_path (
    .mode(mode), .tx_req(tx_req), .idle_ok(idle_ok), .pending(pending),
    .rx_in(rx_in), .tx_bit(tx_bit), .ctl(ctl), .tx_grant(tx_grant),
    .rx_core(rx_core)
  );

  assign mode_stat   = mode;
  assign tx_abort    = abort_pulse;
  assign tx_req_clr  = abort_pulse;
  assign rx_en       = ctl.rx_en;
  assign err_cnt_clr = ctl.err_clr;
  assign err_cnt_run = ctl.err_run;
  assign ack_err_en  = ctl.ack_err_en;
  assign accept_all  = ctl.accept_all;
  assign cfg_wr_en   = ctl.cfg_wr_en;
  assign tx_pin_own  = ctl.tx_pin_own;
  assign rx_pin_own  = ctl.rx_pin_own;
  assign loop_sel    = ctl.loop_sel;
endmodule

// File: rtl/can_mode_ctrl_chk.sv
module can_mode_ctrl_chk #(
  parameter int IDLE_BITS = 11
) (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_tick,
  input logic       rx_in,
  input logic       tx_bit,
  input logic       tx_busy,
  input logic [2:0] mode_stat,
  input logic       switch_now,
  input logic       tx_grant,
  input logic       tx_abort,
  input logic       rx_en,
  input logic       loop_sel,
  input logic       rx_core,
  input logic       wake_evt
);
  localparam int CW = $clog2(IDLE_BITS + 1);
  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n || switch_now)  run_q <= '0;
    else if (bit_tick && !rx_in) run_q <= '0;
    else if (bit_tick && run_q != CW'(IDLE_BITS)) run_q <= run_q + 1'b1;
  end

  AST_STAT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_stat != 3'b101) && (mode_stat != 3'b110)); // R2

  AST_SWITCH_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_stat != $past(mode_stat)) |-> ($past(run_q) == CW'(IDLE_BITS))); // R3

  AST_NO_INIT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_stat == 3'b100 && $past(mode_stat) != 3'b100) |-> !$past(tx_busy)); // R5

  AST_DIS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_stat == 3'b001) |-> (!tx_grant && !rx_en && !loop_sel)); // R7

  AST_LOOP_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    loop_sel |-> (rx_core == tx_bit)); // R9

  AST_GRANT_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_grant |-> (run_q == CW'(IDLE_BITS))); // R11

  AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |=> !tx_abort); // R12

  AST_WAKE_ONLY_DIS: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |-> ($past(mode_stat) == 3'b001)); // R13
endmodule

bind can_mode_ctrl can_mode_ctrl_chk #(.IDLE_BITS(IDLE_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_in(rx_in), .tx_bit(tx_bit),
  .tx_busy(tx_busy), .mode_stat(mode_stat), .switch_now(switch_now),
  .tx_grant(tx_grant), .tx_abort(tx_abort), .rx_en(rx_en), .loop_sel(loop_sel),
  .rx_core(rx_core), .wake_evt(wake_evt)
);

// File: tb/tb_can_mode_ctrl.sv
module tb_can_mode_ctrl;
  localparam int IDLE = 11;
  localparam int FILT = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] mode_req = 3'b100;
  logic bit_tick = 0, rx_in = 1, tx_bit = 1, tx_busy = 0, tx_req = 0;
  logic wake_filt_en = 0, sleep_mode = 0;
  logic [2:0] mode_stat;
  logic tx_grant, tx_abort, tx_req_clr, rx_en, err_cnt_clr, err_cnt_run, ack_err_en;
  logic accept_all, cfg_wr_en, tx_pin_own, rx_pin_own, loop_sel, rx_core, wake_evt;

  int n_chk = 0, n_bad = 0, ab_seen = 0, wk_seen = 0;
  logic [2:0] m_stat, m_tgt;
  int m_cnt, m_wcnt;
  logic m_abl, m_abort, m_wake;

  always #4 clk = ~clk;

  can_mode_ctrl dut (
    .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .bit_tick(bit_tick), .rx_in(rx_in),
    .tx_bit(tx_bit), .tx_busy(tx_busy), .tx_req(tx_req), .wake_filt_en(wake_filt_en),
    .sleep_mode(sleep_mode), .mode_stat(mode_stat), .tx_grant(tx_grant),
    .tx_abort(tx_abort), .tx_req_clr(tx_req_clr), .rx_en(rx_en),
    .err_cnt_clr(err_cnt_clr), .err_cnt_run(err_cnt_run), .ack_err_en(ack_err_en),
    .accept_all(accept_all), .cfg_wr_en(cfg_wr_en), .tx_pin_own(tx_pin_own),
    .rx_pin_own(rx_pin_own), .loop_sel(loop_sel), .rx_core(rx_core), .wake_evt(wake_evt)
  );

  function automatic bit code_ok(input logic [2:0] c);
    return c != 3'b101 && c != 3'b110;
  endfunction

  function automatic bit can_tx(input logic [2:0] m);
    return m == 3'b000 || m == 3'b010;
  endfunction

  // {rx_en, err_clr, err_run, ack_err, accept_all, cfg_wr, tx_pin, rx_pin, loop}
  function automatic logic [8:0] exp_ctl(input logic [2:0] m);
    case (m)
      3'b100:  return 9'b0_1_0_0_0_1_1_1_0;
      3'b000:  return 9'b1_0_1_1_0_0_1_1_0;
      3'b010:  return 9'b1_0_1_1_0_0_0_0_1;
      3'b011:  return 9'b1_0_0_0_0_0_0_1_0;
      3'b111:  return 9'b1_0_0_0_1_0_0_1_0;
      default: return 9'b0;
    endcase
  endfunction

  function automatic string ctl_tag(input logic [2:0] m);
    case (m)
      3'b100:  return "R6";
      3'b001:  return "R7";
      3'b011:  return "R8";
      3'b010:  return "R9";
      3'b111:  return "R10";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_update();
    bit idle, sw, abl;
    if (!rst_n) begin
      m_stat = 3'b100; m_tgt = 3'b100; m_cnt = 0; m_abl = 0; m_abort = 0;
      m_wcnt = 0; m_wake = 0;
    end else begin
      idle = (m_cnt == IDLE);
      sw   = (m_tgt != m_stat) && idle && !(m_tgt == 3'b100 && tx_busy);
      abl  = can_tx(m_stat) && !idle && tx_req && m_tgt == 3'b001;
      m_abort = abl && !m_abl;
      m_abl   = abl;
      if (m_stat != 3'b001) begin
        m_wcnt = 0; m_wake = 0;
      end else if (bit_tick && !rx_in) begin
        m_wake = (wake_filt_en && sleep_mode) ? (m_wcnt == FILT - 1) : 1'b1;
        if (m_wcnt != FILT) m_wcnt++;
      end else begin
        if (bit_tick) m_wcnt = 0;
        m_wake = 0;
      end
      if (sw) m_cnt = 0;
      else if (bit_tick) m_cnt = rx_in ? ((m_cnt == IDLE) ? IDLE : m_cnt + 1) : 0;
      if (sw) m_stat = m_tgt;
      if (code_ok(mode_req)) m_tgt = mode_req;
    end
  endtask

  task automatic compare();
    logic exp_grant, exp_core;
    logic [8:0] e;
    e = exp_ctl(m_stat);
    exp_grant = tx_req && can_tx(m_stat) && m_cnt == IDLE && m_tgt == m_stat;
    exp_core  = e[0] ? tx_bit : (e[1] ? rx_in : 1'b1);
    chk("R3 mode_stat", 32'(mode_stat), 32'(m_stat));
    chk({ctl_tag(m_stat), " controls"},
        32'({rx_en, err_cnt_clr, err_cnt_run, ack_err_en, accept_all, cfg_wr_en,
             tx_pin_own, rx_pin_own, loop_sel}), 32'(e));
    chk("R9 rx_core", 32'(rx_core), 32'(exp_core));
    chk("R11 tx_grant", 32'(tx_grant), 32'(exp_grant));
    chk("R12 tx_abort", 32'({tx_abort, tx_req_clr}), 32'({m_abort, m_abort}));
    chk("R13 wake_evt", 32'(wake_evt), 32'(m_wake));
    if (tx_abort) ab_seen++;
    if (wake_evt) wk_seen++;
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare();
  endtask

  task automatic ticks(input int n, input logic v);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1; rx_in = v; step();
      bit_tick = 0; rx_in = 1; step();
    end
  endtask

  initial begin
    #1_200_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4013));
    @(negedge clk); step(); step();
    rst_n = 1; @(negedge clk);
    chk("R1 reset mode", 32'(mode_stat), 32'h4);
    chk("R1 reset cfg_wr_en", 32'(cfg_wr_en), 32'h1);
    chk("R1 reset pulses", 32'({tx_grant, tx_abort, wake_evt}), 32'h0);

    // R2: invalid code ignored
    mode_req = 3'b101; ticks(14, 1);
    chk("R2 code 101 ignored", 32'(mode_stat), 32'h4);
    mode_req = 3'b000; step(); step();
    chk("R2 enter normal", 32'(mode_stat), 32'h0);

    // R3: 10 recessive not enough, 11th switches
    mode_req = 3'b011; ticks(1, 0); ticks(10, 1);
    chk("R3 still old after 10", 32'(mode_stat), 32'h0);
    ticks(1, 1); step();
    chk("R3 switch after 11", 32'(mode_stat), 32'h3);

    // R4: replacement keeps the count
    mode_req = 3'b010; ticks(1, 0); ticks(6, 1);
    mode_req = 3'b111; step();
    chk("R4 old mode mid-wait", 32'(mode_stat), 32'h3);
    ticks(5, 1); step();
    chk("R4 replaced target entered", 32'(mode_stat), 32'h7);

    // R5: no entry to init while busy
    mode_req = 3'b100; tx_busy = 1; ticks(15, 1);
    chk("R5 held while busy", 32'(mode_stat), 32'h7);
    tx_busy = 0; step(); step();
    chk("R5 enter init when free", 32'(mode_stat), 32'h4);

    // R11/R12: normal, tx right after entry, then disable request aborts
    mode_req = 3'b000; ticks(11, 1); step();
    chk("R2 normal again", 32'(mode_stat), 32'h0);
    tx_req = 1; step();
    chk("R11 no grant in post-entry window", 32'(tx_grant), 32'h0);
    ab_seen = 0; mode_req = 3'b001; step(); step(); step();
    chk("R12 single abort pulse", 32'(ab_seen), 32'h1);
    tx_req = 0; ticks(11, 1); step();
    chk("R7 disable entered", 32'(mode_stat), 32'h1);

    // R13: filtered and unfiltered wake
    wake_filt_en = 1; sleep_mode = 1; wk_seen = 0;
    ticks(2, 0); ticks(1, 1); ticks(2, 0);
    chk("R13 filter rejects short runs", 32'(wk_seen), 32'h0);
    ticks(1, 1); ticks(4, 0);
    chk("R13 filter one pulse per run", 32'(wk_seen), 32'h1);
    wake_filt_en = 0; wk_seen = 0; ticks(1, 1); ticks(2, 0);
    chk("R13 unfiltered each dominant", 32'(wk_seen), 32'h2);

    // R9/R11: loopback, grant after idle
    mode_req = 3'b010; ticks(11, 1); step();
    chk("R9 loopback entered", 32'(mode_stat), 32'h2);
    tx_req = 1; ticks(11, 1);
    chk("R11 grant after idle", 32'(tx_grant), 32'h1);
    tx_bit = 0; step();
    chk("R9 rx_core follows tx_bit", 32'(rx_core), 32'h0);
    tx_bit = 1;

    // random phase
    for (int c = 0; c < 6000; c++) begin
      bit_tick = ($urandom_range(0, 2) == 0);
      rx_in    = ($urandom_range(0, 15) != 0);
      tx_bit   = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 79) == 0) mode_req = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 9) == 0)  tx_busy = ($urandom_range(0, 4) == 0);
      if ($urandom_range(0, 7) == 0)  tx_req = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 199) == 0) wake_filt_en = ~wake_filt_en;
      if ($urandom_range(0, 199) == 0) sleep_mode = ~sleep_mode;
      step();
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule